// File: doc/BRIEF.md
# Iterative Shift-and-Add Multiplier

This block multiplies two 32-bit operands over a fixed run of one step per clock. It treats them as unsigned, or as two's complement when the signed mode input is high. A single wide product register holds the running partial product. The multiplier is loaded into its lower half, so the bit under test each step is always the register's least significant bit. On each step the multiplicand is conditionally added into the upper half. The whole register then moves right by one place, and the adder's carry enters at the top.

Signed operands are reduced to magnitudes when they are loaded. The unsigned core runs on those magnitudes. The sign is applied to the full 64-bit result only as it leaves the block. The caller pulses `start` while the block is idle, waits for the one-cycle `done` strobe, and reads `product`. While the block is working, `start` has no effect.

Top module: `shift_add_mul`

## Requirements
- R1: A `start` pulse sampled while the block is idle (`busy` low) is accepted: `busy` is high from the next cycle, and the operands and `signed_mode` captured at that edge define the result.
- R2: With `signed_mode` low at acceptance, `product` equals the full 64-bit unsigned product of `op_a` and `op_b`.
- R3: With `signed_mode` high at acceptance, both operands are read as two's complement and `product` equals their 64-bit two's-complement product. This includes the operand value 0x80000000 and results of zero.
- R4: `done` is high for exactly one cycle, in the cycle that follows the 32nd clock edge after the accepting edge.
- R5: `busy` is high from the cycle after acceptance through the `done` cycle inclusive, and low at all other times.
- R6: A `start` sampled while `busy` is high, including during the `done` cycle, is ignored. Changes to `op_a`, `op_b` or `signed_mode` at such times have no effect on the current result or on its timing.
- R7: From the `done` cycle until the next accepted `start`, `product` holds the completed result.
- R8: After reset, `busy` and `done` are low and `product` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a multiply; acted on only when idle |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| busy | output | 1 | Multiply in progress or result being strobed |
| done | output | 1 | One-cycle strobe: result is ready |
| product | output | 64 | 64-bit result, valid from `done` until the next accepted start |

## Verification
On every cycle, the embedded assertions check the following:
- the handshake: acceptance raises `busy`, and `done` lasts a single cycle;
- that exactly 32 step cycles separate acceptance from `done`, counted by a dedicated counter;
- that the product register is cleared in its upper half at load;
- that `product` holds steady while idle.

Whether the arithmetic itself is right can only be shown by the bench's scenarios, which compare every result against an independently computed product. Those scenarios include:
- unsigned extremes;
- mixed-sign and most-negative operands;
- zero operands;
- back-to-back operations;
- `start` pulses and operand changes injected mid-run and during the `done` cycle.

// File: rtl/shift_add_mul_pkg.sv
package shift_add_mul_pkg;

    typedef enum logic [1:0] {
        MS_IDLE = 2'd0,
        MS_RUN  = 2'd1,
        MS_DONE = 2'd2
    } mul_state_e;

endpackage

// File: rtl/sam_operand_prep.sv
module sam_operand_prep #(
    parameter int W         = 32,
    parameter bit SIGNED_EN = 1'b1
) (
    input  logic         signed_mode,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output logic         neg_result
);

    generate
        if (SIGNED_EN) begin : g_signed
            logic a_neg;
            logic b_neg;
            always_comb begin
                a_neg      = signed_mode & op_a[W-1];
                b_neg      = signed_mode & op_b[W-1];
                mag_a      = a_neg ? (~op_a + {{(W-1){1'b0}}, 1'b1}) : op_a;
                mag_b      = b_neg ? (~op_b + {{(W-1){1'b0}}, 1'b1}) : op_b;
                neg_result = a_neg ^ b_neg;
            end
        end else begin : g_unsigned
            logic unused_mode;
            always_comb begin
                unused_mode = signed_mode;
                mag_a       = op_a;
                mag_b       = op_b;
                neg_result  = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/sam_control.sv
module sam_control
    import shift_add_mul_pkg::*;
#(
    parameter int W = 32,
    localparam int CW = $clog2(W) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);

    typedef struct packed {
        mul_state_e    state;
        logic [CW-1:0] iter;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        load  = 1'b0;
        step  = 1'b0;
        unique case (ctl_q.state)
            MS_IDLE: begin
                if (start) begin
                    load        = 1'b1;
                    ctl_d.state = MS_RUN;
                    ctl_d.iter  = '0;
                end
            end
            MS_RUN: begin
                step       = 1'b1;
                ctl_d.iter = ctl_q.iter + 1'b1;
                if (ctl_q.iter == CW'(W - 1)) begin
                    ctl_d.state = MS_DONE;
                end
            end
            MS_DONE: begin
                ctl_d.state = MS_IDLE;
            end
            default: ctl_d.state = MS_IDLE;
        endcase
        busy = (ctl_q.state != MS_IDLE);
        done = (ctl_q.state == MS_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: MS_IDLE, iter: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Independent step counter used only to check the run length.
    logic [CW:0] chk_steps_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_steps_q <= '0;
        end else if (load) begin
            chk_steps_q <= '0;
        end else if (step) begin
            chk_steps_q <= chk_steps_q + 1'b1;
        end
    end

    p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_run_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (chk_steps_q == (CW+1)'(W)));

    p_busy_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !load);

endmodule

// File: rtl/sam_datapath.sv
module sam_datapath #(
    parameter int W = 32,
    localparam int PW = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [W-1:0]  mag_a,
    input  logic [W-1:0]  mag_b,
    input  logic          neg_in,
    output logic [PW-1:0] prod_raw,
    output logic          neg_out
);

    typedef struct packed {
        logic [PW-1:0] prod;
        logic [W-1:0]  mcand;
        logic          neg;
    } dp_t;

    dp_t dp_d, dp_q;

    logic [W:0]    partial;
    logic [PW:0]   widened;

    always_comb begin
        dp_d    = dp_q;
        partial = {1'b0, dp_q.prod[PW-1:W]}
                + {1'b0, (dp_q.prod[0] ? dp_q.mcand : {W{1'b0}})};
        widened = {partial, dp_q.prod[W-1:0]};
        if (load) begin
            dp_d.prod  = {{W{1'b0}}, mag_b};
            dp_d.mcand = mag_a;
            dp_d.neg   = neg_in;
        end else if (step) begin
            dp_d.prod = widened[PW:1];
        end
        prod_raw = dp_q.prod;
        neg_out  = dp_q.neg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    p_load_clears_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (prod_raw[PW-1:W] == '0));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(prod_raw));

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
#(
    parameter int W         = 32,
    parameter bit SIGNED_EN = 1'b1,
    localparam int PW = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          signed_mode,
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    output logic          busy,
    output logic          done,
    output logic [PW-1:0] product
);

    logic [W-1:0]  mag_a, mag_b;
    logic          neg_in, neg_q;
    logic          load, step;
    logic [PW-1:0] prod_raw;

    sam_operand_prep #(.W(W), .SIGNED_EN(SIGNED_EN)) u_prep (
        .signed_mode (signed_mode),
        .op_a        (op_a),
        .op_b        (op_b),
        .mag_a       (mag_a),
        .mag_b       (mag_b),
        .neg_result  (neg_in)
    );

    sam_control #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    sam_datapath #(.W(W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .mag_a    (mag_a),
        .mag_b    (mag_b),
        .neg_in   (neg_in),
        .prod_raw (prod_raw),
        .neg_out  (neg_q)
    );

    // Apply the result sign only at the output.
    always_comb begin
        product = neg_q ? (~prod_raw + {{(PW-1){1'b0}}, 1'b1}) : prod_raw;
    end

    p_hold_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done || (!busy && !start)) |=> $stable(product));

    p_done_from_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

endmodule

// File: tb/tb_shift_add_mul.sv
`timescale 1ns/1ps
module tb_shift_add_mul;

    localparam int W   = 32;
    localparam int LAT = 33; // negedges from acceptance-sampling negedge to done

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          signed_mode = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic          busy, done;
    logic [2*W-1:0] product;

    int n_checks = 0;
    int n_fail   = 0;
    logic [2*W-1:0] exp_q[$];

    always #2.5 clk = ~clk;

    shift_add_mul dut (
        .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
        .op_a(op_a), .op_b(op_b), .busy(busy), .done(done), .product(product)
    );

    function automatic logic [2*W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b, logic s);
        logic [2*W-1:0] ea, eb;
        ea = s ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
        eb = s ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
        return ea * eb;
    endfunction

    task automatic check(string req, logic [2*W-1:0] act, logic [2*W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: pushes the expected result, pulses start. Optionally
    // injects an ignored start mid-run and one during the done cycle (R6).
    task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic s, bit disturb);
        exp_q.push_back(ref_mul(a, b, s));
        @(posedge clk); #1;
        op_a = a; op_b = b; signed_mode = s; start = 1'b1;
        @(posedge clk); #1;  // accepting edge k passed
        start = 1'b0;
        if (disturb) begin
            repeat (5) @(posedge clk);
            #1; op_a = ~a; op_b = b ^ 32'h1234_5678; signed_mode = ~s; start = 1'b1;
            @(posedge clk); #1; start = 1'b0;
            repeat (25) @(posedge clk);   // now at edge k+31
            #1; start = 1'b1;             // sampled at k+32 (RUN) and k+33 (DONE)
            @(posedge clk); #1;
            @(posedge clk); #1; start = 1'b0;
        end else begin
            repeat (33) @(posedge clk);
            #1;
        end
        op_a = $urandom; op_b = $urandom; signed_mode = $urandom;
    endtask

    // Monitor / scoreboard
    initial begin
        bit active = 0;
        int lat = 0;
        bit have_held = 0;
        logic [2*W-1:0] held = '0;
        logic [2*W-1:0] e;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (active) lat++;
            check("R5 busy", {63'b0, busy}, {63'b0, (active && lat >= 1)});
            check("R4 done", {63'b0, done}, {63'b0, (active && lat == LAT)});
            if (active && lat == LAT) begin
                if (exp_q.size() == 0) begin
                    check("R2/R3 queue", 64'd0, 64'd1);
                end else begin
                    e = exp_q.pop_front();
                    check("R2 R3 product", product, e);
                    held = e; have_held = 1;
                end
                active = 0;
            end else begin
                if (!active && have_held) check("R7 hold", product, held);
                if (!active && start) begin active = 1; lat = 0; end
            end
        end
    end

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1;
        check("R8 busy", {63'b0, busy}, 64'd0);
        check("R8 done", {63'b0, done}, 64'd0);
        check("R8 product", product, 64'd0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R2 unsigned
        drive(32'd6, 32'd7, 1'b0, 0);
        drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 0);
        drive(32'h8000_0000, 32'd2, 1'b0, 0);
        drive(32'd0, 32'hDEAD_BEEF, 1'b0, 0);
        // R3 signed
        drive(32'hFFFF_FFFA, 32'd7, 1'b1, 0);
        drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 0);
        drive(32'h8000_0000, 32'h8000_0000, 1'b1, 0);
        drive(32'h8000_0000, 32'd1, 1'b1, 0);
        drive(32'h7FFF_FFFF, 32'h8000_0001, 1'b1, 0);
        drive(32'd0, 32'hFFFF_FFFF, 1'b1, 0);
        // R6 ignored starts and operand changes
        drive(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 1);
        drive(32'hF000_0001, 32'h0000_0003, 1'b1, 1);
        for (int i = 0; i < 20; i++) begin
            drive($urandom, $urandom, i[0], i[2]);
        end
        repeat (4) @(posedge clk);
        check("R1 all accepted", 64'(exp_q.size()), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule